// File: doc/BRIEF.md
# Configurable Four-Input Logic Cell

This block is one programmable logic element. Two small look-up tables, each with eight entries, share the three low data inputs as their index. The fourth data input picks which table's answer reaches the combinational output, so the pair can realise any Boolean function of four inputs. A single storage element can capture that function. Its active clock edge, the active levels of its enable and set/reset inputs, and the value that set/reset forces are all chosen by configuration.

All 22 configuration bits live in one internal register that is filled serially before use. While `cfg_en` is high, one bit enters per rising edge of `clk`, least significant bit first. The bit at the far end of the register is driven on `cfg_dout`, so several cells can be chained. Once loading ends, the user inputs drive the cell. A second output presents either the stored bit or the combinational result.

Configuration bit map: bits 7:0 hold table A, used when d[3]=0, with entry k at bit k. Bits 15:8 hold table B, used when d[3]=1, with entry k at bit 8+k. Bit 16 selects the falling clock edge. Bit 17 makes the clock enable active-low. Bit 18 makes set/reset active-low. Bit 19 is the value set/reset forces. Bit 20 routes the stored bit to `sel_out`. Bit 21 makes the storage element ignore the clock enable.

Top module: `cfg_logic_cell`

## Requirements
- R1: After reset, with no configuration loaded, both `comb_out` and `sel_out` read 0.
- R2: While `cfg_en` is high, each rising `clk` edge shifts the configuration register one place toward bit 0, and `cfg_din` enters at bit 21. After 22 shifts, the first bit sent sits in bit 0. `cfg_dout` always shows bit 0, so the old contents leave in order bit 0, bit 1, and so on.
- R3: With `cfg_en` low, `comb_out` equals table A entry d[2:0] when d[3]=0, and table B entry d[2:0] when d[3]=1.
- R4: With `cfg_en` low, `sel_out` equals the stored bit when bit 20 is 1, and equals `comb_out` when bit 20 is 0.
- R5: The storage element updates only on the rising edge of `clk` when bit 16 is 0, and only on the falling edge when bit 16 is 1.
- R6: With set/reset inactive, the stored bit takes `comb_out` on an active edge when the clock enable is active. The enable is active when `ce` is 1 with bit 17 at 0, or `ce` is 0 with bit 17 at 1, or whenever bit 21 is 1. Otherwise the stored bit holds.
- R7: Set/reset is active when `sr` differs from bit 18. When it is active, an active edge loads bit 19 into the storage element, whatever the clock enable is.
- R8: While `cfg_en` is high, both outputs read 0 and the stored bit does not change. When loading ends, the stored bit still holds the value it had before loading.
- R9: Synchronous active-high `rst` clears the configuration register and the stored bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration chain and, through the edge option, the storage element |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_din | input | 1 | Serial configuration data in |
| cfg_dout | output | 1 | Serial configuration data out (register bit 0) |
| d | input | 4 | Data inputs; d[2:0] index the tables, d[3] picks the table |
| ce | input | 1 | Clock enable, level set by configuration |
| sr | input | 1 | Set/reset, level and value set by configuration |
| comb_out | output | 1 | Combinational function output |
| sel_out | output | 1 | Stored or combinational output, per configuration |

## Verification
The bench builds the cell with its default of three table inputs. That gives two eight-entry tables and a 22-bit configuration word, so every one of the 2^6 control combinations and every table entry can be reached within one run. The bench samples outputs both before and after the falling edge of each cycle, which separates rising-edge capture from falling-edge capture. Several reloads are done while the stored bit is 1, which exposes any disturbance during loading. The bench also reads the old configuration word on `cfg_dout` as each new one shifts in.

// File: rtl/cell_cfg_pkg.sv
`timescale 1ns/1ps
package cell_cfg_pkg;

  // Control field, packed LSB first: neg_edge is configuration bit 2*table size.
  typedef struct packed {
    logic ce_ignore;  // storage ignores clock enable
    logic reg_out;    // sel_out shows stored bit
    logic sr_value;   // value forced by set/reset
    logic sr_low;     // set/reset active-low
    logic ce_low;     // clock enable active-low
    logic neg_edge;   // capture on falling edge
  } cell_ctrl_t;

  localparam int CTRL_W = $bits(cell_ctrl_t);

endpackage

// File: rtl/cell_cfg_chain.sv
`timescale 1ns/1ps
module cell_cfg_chain #(
  parameter int W = 22
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         ser_in,
  output logic         ser_out,
  output logic [W-1:0] cfg_q
);

  always_ff @(posedge clk) begin
    if (rst)           cfg_q <= '0;
    else if (shift_en) cfg_q <= {ser_in, cfg_q[W-1:1]};
  end

  assign ser_out = cfg_q[0];

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(cfg_q));

  // R2
  cfg_shift_out_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> ser_out == $past(cfg_q[1]));

endmodule

// File: rtl/cell_lut.sv
`timescale 1ns/1ps
module cell_lut #(
  parameter int N = 3
) (
  input  logic [(1<<N)-1:0] table_bits,
  input  logic [N-1:0]      idx,
  output logic              f
);

  assign f = table_bits[idx];

endmodule

// File: rtl/cell_storage.sv
`timescale 1ns/1ps
module cell_storage (
  input  logic cell_clk,
  input  logic rst,
  input  logic hold,
  input  logic din,
  input  logic ce,
  input  logic sr,
  input  logic ce_low,
  input  logic ce_ignore,
  input  logic sr_low,
  input  logic sr_value,
  output logic q
);

  logic sr_act;
  logic ce_act;

  assign sr_act = sr ^ sr_low;
  assign ce_act = ce_ignore | (ce ^ ce_low);

  always_ff @(posedge cell_clk) begin
    if (rst)         q <= 1'b0;
    else if (hold)   q <= q;
    else if (sr_act) q <= sr_value;
    else if (ce_act) q <= din;
  end

  // R7
  sr_force_chk: assert property (@(posedge cell_clk) disable iff (rst)
    (sr_act && !hold) |=> q == $past(sr_value));

  // R6
  ce_idle_chk: assert property (@(posedge cell_clk) disable iff (rst)
    (!sr_act && !ce_act && !hold) |=> $stable(q));

  // R8
  load_hold_chk: assert property (@(posedge cell_clk) disable iff (rst)
    hold |=> $stable(q));

endmodule

// File: rtl/cfg_logic_cell.sv
`timescale 1ns/1ps
module cfg_logic_cell
  import cell_cfg_pkg::*;
#(
  parameter int LUT_IN = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_en,
  input  logic            cfg_din,
  output logic            cfg_dout,
  input  logic [LUT_IN:0] d,
  input  logic            ce,
  input  logic            sr,
  output logic            comb_out,
  output logic            sel_out
);

  localparam int LUT_SZ = 1 << LUT_IN;
  localparam int CFG_W  = 2 * LUT_SZ + CTRL_W;

  logic [CFG_W-1:0] cfg_q;
  cell_ctrl_t       ctrl;
  logic [1:0]       lut_f;
  logic             merged;
  logic             cell_clk;
  logic             q;

  cell_cfg_chain #(.W(CFG_W)) u_chain (
    .clk      (clk),
    .rst      (rst),
    .shift_en (cfg_en),
    .ser_in   (cfg_din),
    .ser_out  (cfg_dout),
    .cfg_q    (cfg_q)
  );

  assign ctrl = cell_ctrl_t'(cfg_q[CFG_W-1 -: CTRL_W]);

  for (genvar g = 0; g < 2; g++) begin : g_lut
    cell_lut #(.N(LUT_IN)) u_lut (
      .table_bits (cfg_q[g*LUT_SZ +: LUT_SZ]),
      .idx        (d[LUT_IN-1:0]),
      .f          (lut_f[g])
    );
  end

  assign merged   = d[LUT_IN] ? lut_f[1] : lut_f[0];
  assign cell_clk = clk ^ ctrl.neg_edge;

  cell_storage u_store (
    .cell_clk  (cell_clk),
    .rst       (rst),
    .hold      (cfg_en),
    .din       (merged),
    .ce        (ce),
    .sr        (sr),
    .ce_low    (ctrl.ce_low),
    .ce_ignore (ctrl.ce_ignore),
    .sr_low    (ctrl.sr_low),
    .sr_value  (ctrl.sr_value),
    .q         (q)
  );

  assign comb_out = merged & ~cfg_en;
  assign sel_out  = (ctrl.reg_out ? q : merged) & ~cfg_en;

  // R8
  load_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_en |-> (!comb_out && !sel_out));

  // R4
  comb_route_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en && !ctrl.reg_out) |-> sel_out == comb_out);

endmodule

// File: tb/tb_cfg_logic_cell.sv
`timescale 1ns/1ps
module tb_cfg_logic_cell;

  logic       clk = 1'b0;
  logic       rst = 1'b0;
  logic       cfg_en = 1'b0;
  logic       cfg_din = 1'b0;
  logic       cfg_dout;
  logic [3:0] d = '0;
  logic       ce = 1'b0;
  logic       sr = 1'b0;
  logic       comb_out;
  logic       sel_out;

  int total = 0;
  int bad = 0;
  logic [21:0] mcfg = '0;
  logic        mq = 1'b0;

  always #5 clk = ~clk;

  cfg_logic_cell dut (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din), .cfg_dout(cfg_dout),
    .d(d), .ce(ce), .sr(sr), .comb_out(comb_out), .sel_out(sel_out)
  );

  function automatic logic f_comb(logic [21:0] c, logic [3:0] dv);
    return dv[3] ? c[8 + dv[2:0]] : c[dv[2:0]];
  endfunction

  function automatic logic f_next(logic [21:0] c, logic qv, logic [3:0] dv, logic cev, logic srv);
    if (srv ^ c[18]) return c[19];
    if (c[21] | (cev ^ c[17])) return f_comb(c, dv);
    return qv;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic [3:0] dv, input logic cev, input logic srv, input string tag);
    logic nq;
    @(posedge clk);
    #1 d = dv; ce = cev; sr = srv;
    #3;
    chk("R3", comb_out, f_comb(mcfg, dv));
    chk(tag, sel_out, mcfg[20] ? mq : f_comb(mcfg, dv));
    nq = f_next(mcfg, mq, dv, cev, srv);
    #3;
    chk("R5", sel_out, mcfg[20] ? (mcfg[16] ? nq : mq) : f_comb(mcfg, dv));
    mq = nq;
  endtask

  task automatic load(input logic [21:0] c);
    for (int i = 0; i < 22; i++) begin
      @(posedge clk);
      #1 cfg_en = 1'b1; cfg_din = c[i];
      #3;
      chk("R2", cfg_dout, mcfg[i]);
      chk("R8", comb_out, 1'b0);
      chk("R8", sel_out, 1'b0);
    end
    @(posedge clk);
    #1 cfg_en = 1'b0;
    mcfg = c;
    #3 chk("R2", cfg_dout, c[0]);
    // one active edge follows with the inputs left from before
    mq = f_next(mcfg, mq, d, ce, sr);
  endtask

  task automatic do_reset();
    @(posedge clk);
    #1 rst = 1'b1; ce = 1'b0; sr = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    mcfg = '0; mq = 1'b0;
    #3;
    chk("R9", comb_out, 1'b0);
    chk("R1", sel_out, 1'b0);
    chk("R9", cfg_dout, 1'b0);
    mq = f_next(mcfg, mq, d, ce, sr);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [21:0] c;
    void'($urandom(32'h1234_5678));
    do_reset();

    // R3: full 16-entry function sweep, combinational routing
    load({6'b000000, 8'h3C, 8'b1001_0110});
    for (int k = 0; k < 16; k++) step(4'(k), 1'b0, 1'b0, "R4");

    // R6: active-high enable, registered output, rising edge
    load({6'b010000, 8'hFF, 8'hFF});
    step(4'h0, 1'b1, 1'b0, "R6");
    step(4'h0, 1'b0, 1'b0, "R6");
    step(4'h0, 1'b0, 1'b0, "R6");
    // R8: reload while stored bit is 1, ce active-low, tables zero
    load({6'b010010, 8'h00, 8'h00});
    step(4'h1, 1'b1, 1'b0, "R8");
    step(4'h1, 1'b0, 1'b0, "R6");
    step(4'h1, 1'b1, 1'b0, "R6");
    // R6: enable ignored
    load({6'b110000, 8'hAA, 8'h55});
    for (int k = 0; k < 6; k++) step(4'(k * 3), 1'b0, 1'b0, "R6");

    // R7: set beats enable, active-high sr
    load({6'b011000, 8'h00, 8'h00});
    step(4'h2, 1'b1, 1'b1, "R7");
    step(4'h2, 1'b1, 1'b1, "R7");
    step(4'h2, 1'b1, 1'b0, "R7");
    // R7: active-low reset forcing 0 over enable
    load({6'b010100, 8'hFF, 8'hFF});
    step(4'h7, 1'b1, 1'b1, "R7");
    step(4'h7, 1'b0, 1'b0, "R7");
    step(4'h7, 1'b1, 1'b1, "R7");

    // R5: falling-edge capture
    load({6'b010001, 8'hF0, 8'h0F});
    for (int k = 0; k < 8; k++) step(4'(k * 5), 1'b1, 1'b0, "R5");

    // R9: reset mid-run with stored bit set
    load({6'b011000, 8'h00, 8'h00});
    step(4'h0, 1'b0, 1'b1, "R7");
    do_reset();
    load({6'b010000, 8'h00, 8'h00});
    step(4'h0, 1'b0, 1'b0, "R9");

    // random configurations and stimulus
    for (int n = 0; n < 25; n++) begin
      c = 22'($urandom);
      load(c);
      for (int s = 0; s < 40; s++)
        step(4'($urandom), 1'($urandom), 1'(($urandom % 5) == 0), "R4");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule